// File: doc/BRIEF.md
# Stack-Machine Operand Addressing Unit

This unit fetches the source operand for a memory-class instruction of a small 16-bit accumulator machine. The machine keeps an accumulator, an index register, a stack pointer that moves toward lower addresses as values are pushed, and a program counter. When the instruction sequencer pulses `start`, the unit latches the current program counter, stack pointer and index value, together with the opcode and a byte/word flag. It then reads any extra bytes from the instruction stream and works out the effective address. It reads the operand bytes through a single-port synchronous byte memory and delivers a zero-extended 16-bit operand with a one-cycle valid strobe.

Eight addressing modes are supported. The mode comes from the three least significant opcode bits. Two of the modes remove a value from the stack, and the updated stack pointer is returned next to the operand. The updated program counter, which now points past every consumed stream byte, is returned as well. The unit does no arithmetic, stores or branching. It only sequences the operand fetch and the pointer side effects that go with it.

Top module: `opnd_addr_unit`

## Requirements
- R1: The addressing mode is taken from opcode bits [2:0]. Opcode bits [7:3] have no effect on the operand, the pointers or the read sequence.
- R2: Mode 0 (immediate) reads the operand from the instruction stream at the program counter. It reads one byte when `is_word`=0 and two bytes when `is_word`=1.
- R3: Mode 1 (direct) reads a 16-bit address from two stream bytes, low byte first, and then reads the operand at that address.
- R4: Mode 2 reads the operand at the index value. Mode 3 reads one stream byte as an unsigned offset and reads the operand at index+offset, modulo 2^16.
- R5: Mode 4 reads one stream byte as an unsigned offset and reads the operand at SP+offset, modulo 2^16. SP is left unchanged.
- R6: Mode 5 pops the top of stack. It always reads two bytes at SP, whatever `is_word` says, and returns SP+2.
- R7: Modes 6 and 7 read a 16-bit pointer at SP, low byte first, and then read a 1- or 2-byte operand at that pointer. Mode 6 returns SP+2. Mode 7 returns SP unchanged.
- R8: Multi-byte values are little-endian. A one-byte operand is returned with bits [15:8] cleared.
- R9: `pc_out` equals the start PC plus the number of stream bytes consumed (0, 1 or 2). For modes 2, 5, 6 and 7 it equals the start PC.
- R10: Each byte costs exactly one `mem_rd` cycle, and no two reads are back to back. `opnd_valid` is a single-cycle pulse that comes after the last read, at the point where `busy` falls.
- R11: A `start` pulse that arrives while `busy` is high is ignored. The operation in progress completes with its own latched inputs.
- R12: After reset, `busy`, `mem_rd` and `opnd_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operand fetch (accepted when not busy) |
| opcode | input | 8 | Instruction opcode; bits [2:0] select the mode |
| is_word | input | 1 | 1 = 16-bit operand, 0 = 8-bit operand |
| pc_in | input | 16 | Address of the first byte after the opcode |
| sp_in | input | 16 | Current stack pointer |
| idx_in | input | 16 | Current index register |
| mem_rd | output | 1 | Read strobe to the byte memory |
| mem_addr | output | 16 | Read address |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |
| busy | output | 1 | Fetch in progress |
| opnd_valid | output | 1 | One-cycle strobe: operand and pointers ready |
| opnd | output | 16 | Zero-extended operand |
| pc_out | output | 16 | Program counter after the consumed stream bytes |
| sp_out | output | 16 | Stack pointer after any pop |

## Verification
The bench uses an offset byte of 0xF0, so a design that sign-extends the offset lands 256 bytes too low. It also uses an index near the top of the address space to check that the sum wraps. Word and byte variants of the indirect-through-stack modes are run side by side. A swapped pop decision would show up as a wrong `sp_out` in modes 6 and 7, and a pop in byte mode 5 that honours the width flag would return only half the stacked value. Each operation counts its memory reads. This exposes a design that fetches a second immediate byte for a byte operand, or one that re-reads the pointer. The bench also sends a stray `start` in the middle of a fetch. A design that restarts on it would return a different operand and program counter.

// File: rtl/oau_pkg.sv
package oau_pkg;

  typedef enum logic [2:0] {
    AM_IMM    = 3'd0,
    AM_DIR    = 3'd1,
    AM_IDX    = 3'd2,
    AM_IDXOFF = 3'd3,
    AM_SPOFF  = 3'd4,
    AM_POP    = 3'd5,
    AM_TOSPOP = 3'd6,
    AM_TOS    = 3'd7
  } amode_t;

  typedef enum logic [1:0] {
    PH_STREAM = 2'd0,
    PH_PTR    = 2'd1,
    PH_DATA   = 2'd2
  } phase_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_CAPT = 2'd2
  } state_t;

endpackage

// File: rtl/oau_mode_dec.sv
module oau_mode_dec
  import oau_pkg::*;
(
  input  amode_t mode,
  input  logic   is_word,
  output phase_t first_phase,
  output logic   stream_last,
  output logic   data_last,
  output logic   pop_at_ptr,
  output logic   pop_at_data,
  output logic   is_imm
);

  always_comb begin
    first_phase = PH_STREAM;
    stream_last = 1'b0;
    data_last   = is_word;
    pop_at_ptr  = 1'b0;
    pop_at_data = 1'b0;
    is_imm      = 1'b0;
    unique case (mode)
      AM_IMM: begin
        is_imm      = 1'b1;
        stream_last = is_word;
      end
      AM_DIR:    stream_last = 1'b1;
      AM_IDX:    first_phase = PH_DATA;
      AM_IDXOFF: stream_last = 1'b0;
      AM_SPOFF:  stream_last = 1'b0;
      AM_POP: begin
        first_phase = PH_DATA;
        data_last   = 1'b1;
        pop_at_data = 1'b1;
      end
      AM_TOSPOP: begin
        first_phase = PH_PTR;
        pop_at_ptr  = 1'b1;
      end
      AM_TOS:    first_phase = PH_PTR;
      default:   first_phase = PH_STREAM;
    endcase
  end

endmodule

// File: rtl/oau_ea_calc.sv
module oau_ea_calc
  import oau_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  amode_t        mode,
  input  logic [DW-1:0] byte_in,
  input  logic [DW-1:0] lo_byte,
  input  logic [AW-1:0] idx,
  input  logic [AW-1:0] sp,
  output logic [AW-1:0] ea
);

  logic [AW-1:0] ofs_ext;
  logic [AW-1:0] pair;

  assign ofs_ext = {{DW{1'b0}}, byte_in};
  assign pair    = {byte_in, lo_byte};

  always_comb begin
    unique case (mode)
      AM_DIR, AM_TOSPOP, AM_TOS: ea = pair;
      AM_IDX:                    ea = idx;
      AM_IDXOFF:                 ea = idx + ofs_ext;
      AM_SPOFF:                  ea = sp + ofs_ext;
      AM_POP:                    ea = sp;
      default:                   ea = '0;
    endcase
  end

endmodule

// File: rtl/oau_fsm.sv
module oau_fsm
  import oau_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  amode_t        start_mode,
  input  logic          is_word,
  input  logic [AW-1:0] pc_in,
  input  logic [AW-1:0] sp_in,
  input  logic [AW-1:0] idx_in,
  input  phase_t        start_phase,
  input  logic          stream_last,
  input  logic          data_last,
  input  logic          pop_at_ptr,
  input  logic          pop_at_data,
  input  logic          is_imm,
  input  logic [AW-1:0] ea,
  input  logic [DW-1:0] mem_rdata,
  output amode_t        mode_q,
  output logic          word_q,
  output logic [DW-1:0] lo_q,
  output logic [AW-1:0] idx_q,
  output logic [AW-1:0] sp_q,
  output logic [AW-1:0] pc_q,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  output logic          busy,
  output logic          opnd_valid,
  output logic [AW-1:0] opnd
);

  localparam logic [AW-1:0] ONE = AW'(1);
  localparam logic [AW-1:0] TWO = AW'(2);

  state_t        state;
  phase_t        phase;
  logic          cnt;
  logic [AW-1:0] start_addr;
  logic [AW-1:0] assembled;

  always_comb begin
    if (start_phase == PH_STREAM)  start_addr = pc_in;
    else if (start_mode == AM_IDX) start_addr = idx_in;
    else                           start_addr = sp_in;
  end

  assign assembled = cnt ? {mem_rdata, lo_q} : {{DW{1'b0}}, mem_rdata};

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      phase      <= PH_STREAM;
      cnt        <= 1'b0;
      mode_q     <= AM_IMM;
      word_q     <= 1'b0;
      lo_q       <= '0;
      idx_q      <= '0;
      sp_q       <= '0;
      pc_q       <= '0;
      mem_rd     <= 1'b0;
      mem_addr   <= '0;
      busy       <= 1'b0;
      opnd_valid <= 1'b0;
      opnd       <= '0;
    end else begin
      opnd_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            mode_q   <= start_mode;
            word_q   <= is_word;
            pc_q     <= pc_in;
            sp_q     <= sp_in;
            idx_q    <= idx_in;
            cnt      <= 1'b0;
            phase    <= start_phase;
            busy     <= 1'b1;
            mem_rd   <= 1'b1;
            mem_addr <= start_addr;
            state    <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          mem_rd <= 1'b0;
          state  <= ST_CAPT;
        end
        ST_CAPT: begin
          unique case (phase)
            PH_STREAM: begin
              pc_q <= pc_q + ONE;
              if (!cnt && stream_last) begin
                lo_q     <= mem_rdata;
                cnt      <= 1'b1;
                mem_rd   <= 1'b1;
                mem_addr <= mem_addr + ONE;
                state    <= ST_WAIT;
              end else if (is_imm) begin
                opnd       <= assembled;
                busy       <= 1'b0;
                opnd_valid <= 1'b1;
                state      <= ST_IDLE;
              end else begin
                cnt      <= 1'b0;
                phase    <= PH_DATA;
                mem_rd   <= 1'b1;
                mem_addr <= ea;
                state    <= ST_WAIT;
              end
            end
            PH_PTR: begin
              if (!cnt) begin
                lo_q     <= mem_rdata;
                cnt      <= 1'b1;
                mem_rd   <= 1'b1;
                mem_addr <= mem_addr + ONE;
                state    <= ST_WAIT;
              end else begin
                if (pop_at_ptr) sp_q <= sp_q + TWO;
                cnt      <= 1'b0;
                phase    <= PH_DATA;
                mem_rd   <= 1'b1;
                mem_addr <= ea;
                state    <= ST_WAIT;
              end
            end
            default: begin
              if (!cnt && data_last) begin
                lo_q     <= mem_rdata;
                cnt      <= 1'b1;
                mem_rd   <= 1'b1;
                mem_addr <= mem_addr + ONE;
                state    <= ST_WAIT;
              end else begin
                if (pop_at_data) sp_q <= sp_q + TWO;
                opnd       <= assembled;
                busy       <= 1'b0;
                opnd_valid <= 1'b1;
                state      <= ST_IDLE;
              end
            end
          endcase
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/opnd_addr_unit.sv
module opnd_addr_unit
  import oau_pkg::*;
#(
  parameter int DW    = 8,
  parameter int OPC_W = 8,
  localparam int AW   = 2 * DW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [OPC_W-1:0] opcode,
  input  logic             is_word,
  input  logic [AW-1:0]    pc_in,
  input  logic [AW-1:0]    sp_in,
  input  logic [AW-1:0]    idx_in,
  output logic             mem_rd,
  output logic [AW-1:0]    mem_addr,
  input  logic [DW-1:0]    mem_rdata,
  output logic             busy,
  output logic             opnd_valid,
  output logic [AW-1:0]    opnd,
  output logic [AW-1:0]    pc_out,
  output logic [AW-1:0]    sp_out
);

  amode_t        in_mode;
  amode_t        mode_q;
  logic          word_q;
  phase_t        in_phase;
  phase_t        q_phase_unused;
  logic          in_sl_unused, in_dl_unused, in_pp_unused, in_pd_unused, in_imm_unused;
  logic          stream_last, data_last, pop_at_ptr, pop_at_data, is_imm;
  logic [DW-1:0] lo_q;
  logic [AW-1:0] idx_q, sp_q, pc_q, ea;

  assign in_mode = amode_t'(opcode[2:0]);

  oau_mode_dec u_dec_in (
    .mode        (in_mode),
    .is_word     (is_word),
    .first_phase (in_phase),
    .stream_last (in_sl_unused),
    .data_last   (in_dl_unused),
    .pop_at_ptr  (in_pp_unused),
    .pop_at_data (in_pd_unused),
    .is_imm      (in_imm_unused)
  );

  oau_mode_dec u_dec_q (
    .mode        (mode_q),
    .is_word     (word_q),
    .first_phase (q_phase_unused),
    .stream_last (stream_last),
    .data_last   (data_last),
    .pop_at_ptr  (pop_at_ptr),
    .pop_at_data (pop_at_data),
    .is_imm      (is_imm)
  );

  oau_ea_calc #(.DW(DW)) u_ea (
    .mode    (mode_q),
    .byte_in (mem_rdata),
    .lo_byte (lo_q),
    .idx     (idx_q),
    .sp      (sp_q),
    .ea      (ea)
  );

  oau_fsm #(.DW(DW)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .start_mode  (in_mode),
    .is_word     (is_word),
    .pc_in       (pc_in),
    .sp_in       (sp_in),
    .idx_in      (idx_in),
    .start_phase (in_phase),
    .stream_last (stream_last),
    .data_last   (data_last),
    .pop_at_ptr  (pop_at_ptr),
    .pop_at_data (pop_at_data),
    .is_imm      (is_imm),
    .ea          (ea),
    .mem_rdata   (mem_rdata),
    .mode_q      (mode_q),
    .word_q      (word_q),
    .lo_q        (lo_q),
    .idx_q       (idx_q),
    .sp_q        (sp_q),
    .pc_q        (pc_q),
    .mem_rd      (mem_rd),
    .mem_addr    (mem_addr),
    .busy        (busy),
    .opnd_valid  (opnd_valid),
    .opnd        (opnd)
  );

  assign pc_out = pc_q;
  assign sp_out = sp_q;

endmodule

// File: rtl/oau_chk.sv
module oau_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic busy,
  input logic mem_rd,
  input logic opnd_valid
);

  // R10
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    opnd_valid |=> !opnd_valid);

  // R10
  read_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd);

  // R10
  read_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> busy);

  // R10
  valid_ends_busy_chk: assert property (@(posedge clk) disable iff (rst)
    opnd_valid |-> !busy);

  // R11
  busy_from_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  // R12
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !mem_rd && !opnd_valid));

endmodule

bind opnd_addr_unit oau_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .busy       (busy),
  .mem_rd     (mem_rd),
  .opnd_valid (opnd_valid)
);

// File: tb/sim_opnd_addr_unit.sv
`timescale 1ns/1ps
module sim_opnd_addr_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  opcode = '0;
  logic        is_word = 1'b0;
  logic [15:0] pc_in = '0, sp_in = '0, idx_in = '0;
  logic        mem_rd, busy, opnd_valid;
  logic [15:0] mem_addr, opnd, pc_out, sp_out;
  logic [7:0]  mem_rdata = '0;

  logic [7:0]  mem [0:4095];
  int          checks = 0;
  int          failures = 0;
  bit          finished = 0;

  always #2 clk = ~clk;

  opnd_addr_unit u0 (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode), .is_word(is_word),
    .pc_in(pc_in), .sp_in(sp_in), .idx_in(idx_in),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .busy(busy), .opnd_valid(opnd_valid), .opnd(opnd),
    .pc_out(pc_out), .sp_out(sp_out)
  );

  always_ff @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[11:0]];

  function automatic logic [7:0] rd8(input logic [15:0] a);
    return mem[a[11:0]];
  endfunction

  function automatic logic [15:0] rd16(input logic [15:0] a);
    return {rd8(a + 16'd1), rd8(a)};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic [7:0] opc, input logic w,
                       input logic [15:0] pc, input logic [15:0] sp, input logic [15:0] idx,
                       input bit inject,
                       output logic [15:0] r_op, output logic [15:0] r_pc,
                       output logic [15:0] r_sp, output int reads, output logic post_v);
    bit got;
    got = 0;
    reads = 0;
    @(negedge clk);
    opcode = opc; is_word = w; pc_in = pc; sp_in = sp; idx_in = idx; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 60; k++) begin
      if (mem_rd) reads++;
      if (opnd_valid) begin got = 1; break; end
      if (inject && k == 1) begin
        start = 1'b1; opcode = 8'h00; is_word = 1'b0;
        pc_in = 16'h0700; sp_in = 16'h0123; idx_in = 16'h0456;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    if (!got) begin
      failures++;
      $display("FAIL R10 actual=timeout expected=opnd_valid");
    end
    r_op = opnd; r_pc = pc_out; r_sp = sp_out;
    @(negedge clk);
    post_v = opnd_valid;
  endtask

  logic [15:0] op, rp, rs;
  int          nr;
  logic        pv;

  task automatic t_reset();
    chk("R12 busy", {15'd0, busy}, 16'd0);
    chk("R12 mem_rd", {15'd0, mem_rd}, 16'd0);
    chk("R12 opnd_valid", {15'd0, opnd_valid}, 16'd0);
  endtask

  task automatic t_imm();
    mem[12'h100] = 8'hA5; mem[12'h101] = 8'h3C;
    do_op(8'hF8, 1'b0, 16'h0100, 16'h0F00, 16'h0000, 0, op, rp, rs, nr, pv);
    chk("R1 R2 R8 imm byte", op, 16'h00A5);
    chk("R9 imm byte pc", rp, 16'h0101);
    chk("R10 imm byte reads", 16'(nr), 16'd1);
    chk("R10 valid pulse", {15'd0, pv}, 16'd0);
    chk("R1 imm sp untouched", rs, 16'h0F00);
    do_op(8'h40, 1'b1, 16'h0100, 16'h0F00, 16'h0000, 0, op, rp, rs, nr, pv);
    chk("R2 R8 imm word", op, 16'h3CA5);
    chk("R9 imm word pc", rp, 16'h0102);
    chk("R10 imm word reads", 16'(nr), 16'd2);
  endtask

  task automatic t_direct();
    mem[12'h200] = 8'h34; mem[12'h201] = 8'h02;
    mem[12'h234] = 8'h11; mem[12'h235] = 8'h22;
    do_op(8'h09, 1'b1, 16'h0200, 16'h0F00, 16'h0000, 0, op, rp, rs, nr, pv);
    chk("R3 direct word", op, 16'h2211);
    chk("R9 direct pc", rp, 16'h0202);
    chk("R10 direct word reads", 16'(nr), 16'd4);
    do_op(8'h01, 1'b0, 16'h0200, 16'h0F00, 16'h0000, 0, op, rp, rs, nr, pv);
    chk("R3 R8 direct byte", op, 16'h0011);
    chk("R10 direct byte reads", 16'(nr), 16'd3);
  endtask

  task automatic t_index();
    do_op(8'h02, 1'b1, 16'h0333, 16'h0F00, 16'h0300, 0, op, rp, rs, nr, pv);
    chk("R4 idx word", op, rd16(16'h0300));
    chk("R9 idx pc unchanged", rp, 16'h0333);
    mem[12'h400] = 8'hF0;
    do_op(8'h03, 1'b0, 16'h0400, 16'h0F00, 16'h0510, 0, op, rp, rs, nr, pv);
    chk("R4 idx+unsigned ofs byte", op, {8'h00, rd8(16'h0600)});
    chk("R9 idx ofs pc", rp, 16'h0401);
    mem[12'h402] = 8'h20;
    do_op(8'h03, 1'b1, 16'h0402, 16'h0F00, 16'hFFF0, 0, op, rp, rs, nr, pv);
    chk("R4 idx ofs wrap", op, rd16(16'h0010));
  endtask

  task automatic t_spoff();
    mem[12'h420] = 8'h85;
    do_op(8'h04, 1'b1, 16'h0420, 16'h0800, 16'h0000, 0, op, rp, rs, nr, pv);
    chk("R5 sp ofs word", op, rd16(16'h0885));
    chk("R5 sp unchanged", rs, 16'h0800);
    chk("R9 sp ofs pc", rp, 16'h0421);
  endtask

  task automatic t_pop();
    do_op(8'h05, 1'b0, 16'h0440, 16'h0900, 16'h0000, 0, op, rp, rs, nr, pv);
    chk("R6 pop byte mode gives 16 bits", op, rd16(16'h0900));
    chk("R6 pop sp+2", rs, 16'h0902);
    chk("R6 pop reads", 16'(nr), 16'd2);
    chk("R9 pop pc unchanged", rp, 16'h0440);
  endtask

  task automatic t_tos();
    mem[12'hA00] = 8'h40; mem[12'hA01] = 8'h0B;
    do_op(8'h06, 1'b1, 16'h0450, 16'h0A00, 16'h0000, 0, op, rp, rs, nr, pv);
    chk("R7 tos pop word", op, rd16(16'h0B40));
    chk("R7 tos pop sp", rs, 16'h0A02);
    chk("R7 tos pop reads", 16'(nr), 16'd4);
    do_op(8'h07, 1'b0, 16'h0450, 16'h0A00, 16'h0000, 0, op, rp, rs, nr, pv);
    chk("R7 R8 tos keep byte", op, {8'h00, rd8(16'h0B40)});
    chk("R7 tos keep sp", rs, 16'h0A00);
    chk("R7 tos keep reads", 16'(nr), 16'd3);
    chk("R9 tos pc unchanged", rp, 16'h0450);
  endtask

  task automatic t_busy();
    do_op(8'h09, 1'b1, 16'h0200, 16'h0F00, 16'h0000, 1, op, rp, rs, nr, pv);
    chk("R11 restart ignored operand", op, 16'h2211);
    chk("R11 restart ignored pc", rp, 16'h0202);
    chk("R11 restart ignored sp", rs, 16'h0F00);
    chk("R11 restart ignored reads", 16'(nr), 16'd4);
    chk("R11 idle afterwards", {15'd0, busy}, 16'd0);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 3));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_imm();
    t_direct();
    t_index();
    t_spoff();
    t_pop();
    t_tos();
    t_busy();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL R10 actual=watchdog expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule